// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Start

This block produces the word address for a synchronous burst memory. A burst begins when either of two start strobes is seen on a rising clock edge. One strobe comes from the processor side and one from the memory controller side. At the start of a burst the block captures the full external address. After that, the block keeps the upper address bits fixed and generates the low two bits from an internal counter. The counter steps once for each cycle in which the advance input is high.

A mode input chooses the order of the low bits. Interleaved order combines the start bits with the count by XOR. Linear order adds the count to the start bits and wraps modulo four. The mode value is captured when a burst starts.

Three enables qualify each start. When the main enable is low, the processor strobe is ignored completely. A start seen while any enable is low deselects the device and cancels any burst in progress. The outputs are the current address and an active flag.

Top module: `burst_addr_seq`

## Requirements
- R1: Inputs are sampled only on the rising clock edge, and the outputs change only after such an edge. A synchronous reset (rst_n low) gives addr_out = 0 and active = 0.
- R2: The processor strobe (strobe_cpu = 1), with sel_main, sel_b and sel_c all 1, makes addr_out equal to addr_in and active equal to 1 after the next edge.
- R3: The controller strobe (strobe_ctl = 1), with all three enables at 1, loads the address and sets active in the same way as R2.
- R4: When order_lin = 0 (interleaved), the low two bits equal the start bits XOR the count. For example, start 10 gives 10, 11, 00, 01, and start 01 gives 01, 00, 11, 10.
- R5: When order_lin = 1 (linear), the low two bits equal (start bits + count) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R6: order_lin is captured at the start of a burst. Changing it during the burst has no effect on the sequence.
- R7: While sel_main = 0, the processor strobe is ignored. If strobe_ctl and adv are both 0 in that cycle, addr_out and active do not change.
- R8: If any enable is 0 in a cycle that has a valid strobe, active is 0 after the edge. The controller strobe is not masked by sel_main, so a controller strobe with sel_main = 0 deselects. sel_b and sel_c have no effect in cycles without a strobe.
- R9: While a burst runs, the upper address bits never change. After four advances the low bits return to the start value.
- R10: With no strobe and no advance, addr_out and active hold their values. An advance while inactive has no effect.
- R11: A valid start in the same cycle as an advance loads the new address with count 0. The advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | AW (18) | External address captured at burst start |
| strobe_cpu | input | 1 | Processor-side burst start, masked by sel_main |
| strobe_ctl | input | 1 | Controller-side burst start |
| adv | input | 1 | Step the burst counter |
| sel_main | input | 1 | Main enable, high to select |
| sel_b | input | 1 | Secondary enable, high to select, used only with a strobe |
| sel_c | input | 1 | Secondary enable, high to select, used only with a strobe |
| order_lin | input | 1 | 1 selects linear order, 0 selects interleaved order |
| addr_out | output | AW (18) | Current word address |
| active | output | 1 | 1 while selected, 0 when deselected |

## Verification
Two functions can fall in the same cycle: a burst start and an advance. A start can also carry masked or disabled enables while an advance is pending. The bench provokes this directly: it raises a strobe together with adv in the middle of a running burst. It also drives a masked processor strobe together with adv, where the advance must still step the counter. A behavioural model compares every cycle and judges each case. A start that is valid must win with count 0. A masked processor strobe must not stop the step, and a deselecting start must stop it.

// File: rtl/bas_pkg.sv
// Shared types for the burst address sequencer.
// Assumes: only enum types are needed; no data lives here.
package bas_pkg;
    typedef enum logic {
        ORD_XOR  = 1'b0,
        ORD_WRAP = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_DESEL = 2'd2,
        ACT_STEP  = 2'd3
    } act_e;
endpackage

// File: rtl/bas_start_qual.sv
// Decides the action for the next edge from the strobes, enables and advance.
// Assumes: all inputs are stable around the rising edge; active comes from state.
module bas_start_qual
    import bas_pkg::*;
(
    input  logic strobe_cpu,
    input  logic strobe_ctl,
    input  logic adv,
    input  logic sel_main,
    input  logic sel_b,
    input  logic sel_c,
    input  logic active,
    output act_e act
);
    logic cpu_ok;
    logic start;
    logic selected;

    // Qualify the strobes: the processor strobe is masked by the main enable.
    always_comb begin
        cpu_ok   = strobe_cpu & sel_main;
        start    = cpu_ok | strobe_ctl;
        selected = sel_main & sel_b & sel_c;
    end

    // Choose the action; a start outranks an advance.
    always_comb begin
        if (start)
            act = selected ? ACT_LOAD : ACT_DESEL;
        else if (adv && active)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/bas_state.sv
// Holds the captured base address, burst count, order mode and active flag.
// Assumes: act is already qualified; reset is synchronous and active low.
module bas_state
    import bas_pkg::*;
#(
    parameter int AW = 18,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  act_e          act,
    input  logic [AW-1:0] addr_in,
    input  logic          order_lin,
    output logic [AW-1:0] base_q,
    output logic [CW-1:0] cnt_q,
    output order_e        order_q,
    output logic          active_q
);
    // Update the registers for the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            cnt_q    <= '0;
            order_q  <= ORD_XOR;
            active_q <= 1'b0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    base_q   <= addr_in;
                    cnt_q    <= '0;
                    order_q  <= order_lin ? ORD_WRAP : ORD_XOR;
                    active_q <= 1'b1;
                end
                ACT_DESEL: active_q <= 1'b0;
                ACT_STEP:  cnt_q    <= cnt_q + 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/bas_lowgen.sv
// Forms the low address bits from the start bits and the count.
// Assumes: the count wraps naturally at 2**CW.
module bas_lowgen
    import bas_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic [CW-1:0] start_low,
    input  logic [CW-1:0] cnt,
    input  order_e        order,
    output logic [CW-1:0] low
);
    logic [CW-1:0] xor_low;
    logic [CW-1:0] sum_low;

    // Interleaved order: XOR each bit of the start with the count.
    for (genvar i = 0; i < CW; i++) begin : g_xor
        assign xor_low[i] = start_low[i] ^ cnt[i];
    end

    // Linear order: add the count, wrapping modulo 2**CW.
    assign sum_low = start_low + cnt;

    // Pick the order captured at burst start.
    always_comb low = (order == ORD_WRAP) ? sum_low : xor_low;
endmodule

// File: rtl/burst_addr_seq.sv
// Top of the burst address sequencer: qualifies the starts, keeps the state
// and forms the address. Assumes AW > CW and a single clock domain.
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int AW = 18,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic          strobe_cpu,
    input  logic          strobe_ctl,
    input  logic          adv,
    input  logic          sel_main,
    input  logic          sel_b,
    input  logic          sel_c,
    input  logic          order_lin,
    output logic [AW-1:0] addr_out,
    output logic          active
);
    localparam int UW = AW - CW;

    act_e          act;
    logic [AW-1:0] base_q;
    logic [CW-1:0] cnt_q;
    order_e        order_q;
    logic [CW-1:0] low;

    bas_start_qual u_qual (
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .adv        (adv),
        .sel_main   (sel_main),
        .sel_b      (sel_b),
        .sel_c      (sel_c),
        .active     (active),
        .act        (act)
    );

    bas_state #(.AW(AW), .CW(CW)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .addr_in   (addr_in),
        .order_lin (order_lin),
        .base_q    (base_q),
        .cnt_q     (cnt_q),
        .order_q   (order_q),
        .active_q  (active)
    );

    bas_lowgen #(.CW(CW)) u_low (
        .start_low (base_q[CW-1:0]),
        .cnt       (cnt_q),
        .order     (order_q),
        .low       (low)
    );

    // Upper bits come from the captured base; low bits from the generator.
    assign addr_out = {base_q[AW-1:AW-UW], low};
endmodule

// File: rtl/bas_checker.sv
// Port-level properties of the burst address sequencer, bound to the top.
// Assumes: synchronous active-low reset; all checks are disabled during reset.
module bas_checker #(
    parameter int AW = 18,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_in,
    input logic          strobe_cpu,
    input logic          strobe_ctl,
    input logic          adv,
    input logic          sel_main,
    input logic          sel_b,
    input logic          sel_c,
    input logic [AW-1:0] addr_out,
    input logic          active
);
    logic all_sel;
    assign all_sel = sel_main & sel_b & sel_c;

    p_cpu_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_cpu && all_sel) |=> (addr_out == $past(addr_in)) && active);

    p_ctl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_ctl && all_sel) |=> (addr_out == $past(addr_in)) && active);

    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_cpu && !sel_main && !strobe_ctl && !adv) |=> $stable(addr_out) && $stable(active));

    p_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_ctl && !all_sel) |=> !active);

    p_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !strobe_cpu && !strobe_ctl) |=> $stable(addr_out[AW-1:CW]));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu && !strobe_ctl && !adv) |=> $stable(addr_out) && $stable(active));

    p_idle_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !strobe_cpu && !strobe_ctl) |=> !active && $stable(addr_out));

    p_start_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_cpu && all_sel && adv) |=> addr_out == $past(addr_in));
endmodule

bind burst_addr_seq bas_checker #(.AW(AW), .CW(CW)) u_bas_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_in    (addr_in),
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .adv        (adv),
    .sel_main   (sel_main),
    .sel_b      (sel_b),
    .sel_c      (sel_c),
    .addr_out   (addr_out),
    .active     (active)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_cpu = 1'b0, strobe_ctl = 1'b0, adv = 1'b0;
    logic          sel_main = 1'b0, sel_b = 1'b0, sel_c = 1'b0, order_lin = 1'b0;
    logic [AW-1:0] addr_out;
    logic          active;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    int m_base = 0, m_cnt = 0, m_act = 0, m_lin = 0;

    burst_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .adv(adv),
        .sel_main(sel_main), .sel_b(sel_b), .sel_c(sel_c),
        .order_lin(order_lin), .addr_out(addr_out), .active(active)
    );

    always #2 clk = ~clk;

    function automatic int model_addr();
        int low;
        low = m_lin ? ((m_base % 4) + m_cnt) % 4 : ((m_base % 4) ^ m_cnt);
        return (m_base / 4) * 4 + low;
    endfunction

    task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    task automatic compare(input string tag);
        check(int'(addr_out) == model_addr(), {tag, " addr"}, int'(addr_out), model_addr());
        check(int'(active) == m_act, {tag, " active"}, int'(active), m_act);
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge,
    // compare at the next falling edge.
    task automatic step(input bit sc, input bit sk, input bit av, input bit m,
                        input bit b, input bit c, input bit ol, input int a,
                        input string tag);
        bit start;
        strobe_cpu = sc; strobe_ctl = sk; adv = av;
        sel_main = m; sel_b = b; sel_c = c; order_lin = ol;
        addr_in = AW'(a);
        @(posedge clk);
        start = (sc && m) || sk;
        if (start) begin
            if (m && b && c) begin
                m_base = a; m_cnt = 0; m_lin = ol; m_act = 1;
            end else begin
                m_act = 0;
            end
        end else if (av && m_act == 1) begin
            m_cnt = (m_cnt + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic expect_low(input int v, input string tag);
        check(int'(addr_out[1:0]) == v, {tag, " low bits"}, int'(addr_out[1:0]), v);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(addr_out == '0, "R1 reset addr", int'(addr_out), 0);
        check(active == 1'b0, "R1 reset active", int'(active), 0);

        // R2, R4: processor start at ...10, interleaved
        step(1,0,0,1,1,1,0, 18'h2A5F6, "R2 cpu load");
        expect_low(2, "R2");
        step(0,0,1,1,1,1,0, 0, "R4 step1"); expect_low(3, "R4");
        step(0,0,0,1,1,1,0, 0, "R10 hold");
        step(0,0,1,1,1,1,0, 0, "R4 step2"); expect_low(0, "R4");
        step(0,0,1,1,1,1,0, 0, "R4 step3"); expect_low(1, "R4");
        step(0,0,1,1,1,1,0, 0, "R9 wrap");  expect_low(2, "R9");
        check(addr_out[AW-1:2] == 16'hA97D, "R9 upper", int'(addr_out[AW-1:2]), 16'hA97D);

        // R3, R5, R6: controller start at ...01, linear, order toggled mid-burst
        step(0,1,0,1,1,1,1, 18'h01235, "R3 ctl load");
        expect_low(1, "R3");
        step(0,0,1,1,1,1,0, 0, "R6 step1"); expect_low(2, "R6");
        step(0,0,1,1,1,1,0, 0, "R5 step2"); expect_low(3, "R5");
        step(0,0,1,1,1,1,1, 0, "R5 step3"); expect_low(0, "R5");

        // R4: interleaved from 01
        step(1,0,0,1,1,1,0, 18'h3FFF1, "R4 load01");
        step(0,0,1,1,1,1,0, 0, "R4 x1"); expect_low(0, "R4");
        step(0,0,1,1,1,1,0, 0, "R4 x2"); expect_low(3, "R4");
        step(0,0,1,1,1,1,0, 0, "R4 x3"); expect_low(2, "R4");

        // R7: masked processor strobe ignored; with adv it still steps
        step(1,0,0,0,1,1,1, 18'h00004, "R7 masked");
        step(1,0,1,0,0,0,1, 18'h00008, "R7 masked with adv");
        check(active == 1'b1, "R7 still active", int'(active), 1);

        // R8: secondary enables ignored without strobe
        step(0,0,0,1,0,0,0, 0, "R8 no strobe");
        check(active == 1'b1, "R8 no strobe active", int'(active), 1);
        // R8: controller strobe with main enable low deselects
        step(0,1,0,0,1,1,0, 18'h11111, "R8 ctl desel");
        check(active == 1'b0, "R8 desel", int'(active), 0);
        step(0,0,1,1,1,1,0, 0, "R10 adv inactive");
        // R8: processor strobe with a secondary enable low deselects
        step(1,0,0,1,1,1,0, 18'h00100, "R2 reload");
        step(1,0,1,1,0,1,0, 18'h00200, "R8 cpu desel");
        check(active == 1'b0, "R8 cpu desel", int'(active), 0);

        // R11: start and advance in the same cycle
        step(0,1,0,1,1,1,1, 18'h00402, "R11 setup");
        step(0,0,1,1,1,1,1, 0, "R11 step");
        step(1,0,1,1,1,1,1, 18'h2F00E, "R11 start wins");
        check(addr_out == 18'h2F00E, "R11 count zero", int'(addr_out), 32'h2F00E);

        // Mixed stimulus, model compared each cycle
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            step(r[0] & r[1], r[2] & r[3] & r[4], r[5], r[6] | r[7], r[8] | r[9],
                 r[10] | r[11], r[12], int'($urandom) & 32'h3FFFF, "R10 mixed");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule